// File: doc/BRIEF.md
# Interrupt Recognition and Priority Unit

This unit sits next to a simple instruction sequencer. At every instruction boundary it decides whether the processor enters an interrupt, and which one. It collects five kinds of event. A divide-error pulse comes from the execution unit. A single-step trap flag is held inside the unit. An asynchronous non-maskable line is synchronised, checked for minimum width and latched as pending. A level-sensitive maskable line is gated by the interrupt-enable flag, which the unit also holds. The boundary strobe is the signal that lets any of these events turn into an entry.

When the unit chooses a fixed source, it pulses `take_o` with the fixed vector type in the cycle after the boundary. When it chooses the maskable line, it first raises a one-cycle acknowledge to the external interrupt controller. It then captures the controller's type byte from `type_i` and pulses `take_o` with that byte one cycle later. Every entry clears the enable and trap flags. The sequencer sets those flags again through the write ports.

Top module: `irq_recog_unit`

## Requirements
- R1: After synchronous reset, `take_o`, `ack_o`, `ie_o` and `tf_o` are 0 and nothing is pending, so a boundary with no new event causes no entry.
- R2: The non-maskable line passes through a two-flop synchroniser. It becomes pending only when it is seen high on NMI_MIN_CYC (default 2) consecutive clocks. A one-cycle pulse is dropped.
- R3: A pending non-maskable request causes no entry until the next boundary. It is taken whatever the state of the enable flag, with vector type 8'h02.
- R4: Entry for the non-maskable source clears its pending bit. If the line stays high after that, it does not request again. The line has to fall and then be held high again.
- R5: At a boundary the fixed ranking is divide error (type 8'h00), then trap flag (type 8'h01), then non-maskable (type 8'h02), then maskable. Only the highest-ranked active source is taken.
- R6: A divide-error pulse is held until a boundary. Only that boundary's entry consumes it.
- R7: The maskable line is ignored while `ie_o` is 0.
- R8: The maskable line is sampled at the rising edge where `boundary_i` is high. A line that rises after that edge waits for the next boundary.
- R9: For a maskable entry, `ack_o` is high for exactly the one cycle after the boundary edge. `type_i` is captured at the edge that ends that cycle. `take_o` is then high for one cycle with `vec_o` equal to the captured byte.
- R10: Every entry clears `ie_o` and `tf_o` at the boundary edge. If a flag write arrives at the same edge, the clear wins.
- R11: For a fixed source, `take_o` is a one-cycle pulse in the cycle after the boundary edge. A boundary during the acknowledge cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_async_i | input | 1 | Asynchronous non-maskable request |
| mreq_i | input | 1 | Level-sensitive maskable request |
| ie_wr_i | input | 1 | Write strobe for the enable flag |
| ie_val_i | input | 1 | Value written to the enable flag |
| tf_wr_i | input | 1 | Write strobe for the trap flag |
| tf_val_i | input | 1 | Value written to the trap flag |
| div_err_i | input | 1 | Divide-error pulse |
| boundary_i | input | 1 | High on the last clock of an instruction |
| type_i | input | TYPE_W | Type byte from the external controller |
| take_o | output | 1 | One-cycle interrupt-entry pulse |
| vec_o | output | TYPE_W | Vector type, valid with `take_o` |
| ack_o | output | 1 | One-cycle acknowledge to the controller |
| ie_o | output | 1 | Current enable flag |
| tf_o | output | 1 | Current trap flag |

## Verification
A stuck or lost pending bit shows up at the next boundary: it produces an entry nobody requested, a missing entry, or the wrong vector. Each of these is visible one cycle after the boundary edge. A faulty acknowledge sequencer shows within two cycles as a missing or stretched `ack_o`, or as a wrong captured type. A missed flag clear shows on `ie_o`/`tf_o` right after entry. It also shows a boundary later as a second, unwanted maskable or trap entry. The random mix of sources keeps pending events alive across several boundaries, so that priority and consumption mistakes reach the ports.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_DIV  = 3'd1,
    SRC_TRAP = 3'd2,
    SRC_NMI  = 3'd3,
    SRC_MASK = 3'd4
  } irq_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1
  } irq_state_e;

  localparam int unsigned VEC_DIV  = 0;
  localparam int unsigned VEC_TRAP = 1;
  localparam int unsigned VEC_NMI  = 2;
endpackage

// File: rtl/irq_nmi_qual.sv
module irq_nmi_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_CYC     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic nmi_async_i,
  input  logic clear_i,
  output logic pend_o
);
  localparam int unsigned CNT_W = (MIN_CYC < 2) ? 1 : $clog2(MIN_CYC);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(MIN_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       run_q;
  logic                   fired_q;
  logic                   pend_q;
  logic                   nmi_lvl;
  logic                   qualify;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= nmi_async_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign nmi_lvl = sync_q[SYNC_STAGES-1];
  // one qualification per high stretch
  assign qualify = nmi_lvl && (run_q == RUN_LAST) && !fired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      fired_q <= 1'b0;
    end else if (!nmi_lvl) begin
      run_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (run_q < RUN_LAST) run_q <= run_q + 1'b1;
      if (qualify)          fired_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (qualify) pend_q <= 1'b1;
    else if (clear_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R2
  nmi_rise_seen_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(nmi_lvl));

  if (MIN_CYC >= 2) begin : g_width_chk
    // R2
    nmi_width_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_q) |-> ($past(nmi_lvl) && $past(nmi_lvl, 2)));
  end

  // R4
  nmi_clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> $past(clear_i));
endmodule

// File: rtl/irq_flags.sv
module irq_flags (
  input  logic clk,
  input  logic rst,
  input  logic ie_wr_i,
  input  logic ie_val_i,
  input  logic tf_wr_i,
  input  logic tf_val_i,
  input  logic entry_i,
  output logic ie_o,
  output logic tf_o
);
  logic ie_q;
  logic tf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q <= 1'b0;
      tf_q <= 1'b0;
    end else if (entry_i) begin
      ie_q <= 1'b0;
      tf_q <= 1'b0;
    end else begin
      if (ie_wr_i) ie_q <= ie_val_i;
      if (tf_wr_i) tf_q <= tf_val_i;
    end
  end

  assign ie_o = ie_q;
  assign tf_o = tf_q;

  // R10
  entry_clears_flags_chk: assert property (@(posedge clk) disable iff (rst)
    entry_i |=> (!ie_q && !tf_q));
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_pkg::*;
#(
  parameter int unsigned TYPE_W = 8
) (
  input  logic              div_any_i,
  input  logic              tf_i,
  input  logic              nmi_pend_i,
  input  logic              mreq_i,
  input  logic              ie_i,
  output irq_src_e          sel_o,
  output logic [TYPE_W-1:0] fix_vec_o
);
  always_comb begin
    sel_o     = SRC_NONE;
    fix_vec_o = '0;
    if (div_any_i) begin
      sel_o     = SRC_DIV;
      fix_vec_o = TYPE_W'(VEC_DIV);
    end else if (tf_i) begin
      sel_o     = SRC_TRAP;
      fix_vec_o = TYPE_W'(VEC_TRAP);
    end else if (nmi_pend_i) begin
      sel_o     = SRC_NMI;
      fix_vec_o = TYPE_W'(VEC_NMI);
    end else if (mreq_i && ie_i) begin
      sel_o     = SRC_MASK;
    end
  end
endmodule

// File: rtl/irq_recog_unit.sv
module irq_recog_unit
  import irq_pkg::*;
#(
  parameter int unsigned NMI_SYNC_STAGES = 2,
  parameter int unsigned NMI_MIN_CYC     = 2,
  parameter int unsigned TYPE_W          = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_async_i,
  input  logic              mreq_i,
  input  logic              ie_wr_i,
  input  logic              ie_val_i,
  input  logic              tf_wr_i,
  input  logic              tf_val_i,
  input  logic              div_err_i,
  input  logic              boundary_i,
  input  logic [TYPE_W-1:0] type_i,
  output logic              take_o,
  output logic [TYPE_W-1:0] vec_o,
  output logic              ack_o,
  output logic              ie_o,
  output logic              tf_o
);
  irq_state_e        st_q;
  irq_src_e          sel;
  logic [TYPE_W-1:0] fix_vec;
  logic              div_pend_q;
  logic              div_any;
  logic              nmi_pend;
  logic              accept;
  logic              nmi_clear;

  assign div_any   = div_pend_q || div_err_i;
  assign accept    = (st_q == ST_IDLE) && boundary_i && (sel != SRC_NONE);
  assign nmi_clear = accept && (sel == SRC_NMI);

  irq_nmi_qual #(
    .SYNC_STAGES (NMI_SYNC_STAGES),
    .MIN_CYC     (NMI_MIN_CYC)
  ) u_nmi_qual (
    .clk         (clk),
    .rst         (rst),
    .nmi_async_i (nmi_async_i),
    .clear_i     (nmi_clear),
    .pend_o      (nmi_pend)
  );

  irq_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .ie_wr_i  (ie_wr_i),
    .ie_val_i (ie_val_i),
    .tf_wr_i  (tf_wr_i),
    .tf_val_i (tf_val_i),
    .entry_i  (accept),
    .ie_o     (ie_o),
    .tf_o     (tf_o)
  );

  irq_prio #(
    .TYPE_W (TYPE_W)
  ) u_prio (
    .div_any_i  (div_any),
    .tf_i       (tf_o),
    .nmi_pend_i (nmi_pend),
    .mreq_i     (mreq_i),
    .ie_i       (ie_o),
    .sel_o      (sel),
    .fix_vec_o  (fix_vec)
  );

  // divide error stays pending until an entry chooses it
  always_ff @(posedge clk) begin
    if (rst)                           div_pend_q <= 1'b0;
    else if (accept && sel == SRC_DIV) div_pend_q <= 1'b0;
    else if (div_err_i)                div_pend_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      take_o <= 1'b0;
      ack_o  <= 1'b0;
      vec_o  <= '0;
    end else begin
      take_o <= 1'b0;
      ack_o  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (sel == SRC_MASK) begin
              ack_o <= 1'b1;
              st_q  <= ST_ACK;
            end else begin
              take_o <= 1'b1;
              vec_o  <= fix_vec;
            end
          end
        end
        ST_ACK: begin
          take_o <= 1'b1;
          vec_o  <= type_i;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!take_o && !ack_o && !ie_o && !tf_o));

  // R9
  ack_then_take_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> (take_o && !ack_o && vec_o == $past(type_i)));

  // R5
  div_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && boundary_i && div_any) |=>
      (take_o && !ack_o && vec_o == TYPE_W'(VEC_DIV)));

  // R3
  nmi_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && boundary_i && nmi_pend && !div_any && !tf_o) |=>
      (take_o && vec_o == TYPE_W'(VEC_NMI)));

  // R7
  mask_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && boundary_i && !ie_o && !div_any && !tf_o && !nmi_pend) |=>
      (!take_o && !ack_o));

  // R11
  ack_ignores_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && boundary_i) |=> !ack_o);
endmodule

// File: tb/irq_recog_unit_bench.sv
module irq_recog_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nmi_async_i = 1'b0;
  logic       mreq_i = 1'b0;
  logic       ie_wr_i = 1'b0;
  logic       ie_val_i = 1'b0;
  logic       tf_wr_i = 1'b0;
  logic       tf_val_i = 1'b0;
  logic       div_err_i = 1'b0;
  logic       boundary_i = 1'b0;
  logic [7:0] type_i = 8'h00;
  logic       take_o;
  logic [7:0] vec_o;
  logic       ack_o;
  logic       ie_o;
  logic       tf_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_recog_unit u_irq_recog_unit (
    .clk (clk), .rst (rst), .nmi_async_i (nmi_async_i), .mreq_i (mreq_i),
    .ie_wr_i (ie_wr_i), .ie_val_i (ie_val_i), .tf_wr_i (tf_wr_i), .tf_val_i (tf_val_i),
    .div_err_i (div_err_i), .boundary_i (boundary_i), .type_i (type_i),
    .take_o (take_o), .vec_o (vec_o), .ack_o (ack_o), .ie_o (ie_o), .tf_o (tf_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; nmi_async_i = 1'b0; mreq_i = 1'b0; div_err_i = 1'b0;
    boundary_i = 1'b0; ie_wr_i = 1'b0; tf_wr_i = 1'b0;
    tick(4);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic write_flags(input bit ie, input bit tf);
    ie_wr_i = 1'b1; ie_val_i = ie; tf_wr_i = 1'b1; tf_val_i = tf;
    tick(1);
    ie_wr_i = 1'b0; tf_wr_i = 1'b0;
  endtask

  task automatic nmi_pulse(input int len);
    nmi_async_i = 1'b1;
    tick(len);
    nmi_async_i = 1'b0;
    tick(4);
  endtask

  task automatic boundary_strobe();
    boundary_i = 1'b1;
    tick(1);
    boundary_i = 1'b0;
  endtask

  // returns 0 none, 1 div, 2 trap, 3 nmi, 4 maskable
  function automatic int exp_src(bit d, bit t, bit n, bit m);
    if (d) return 1;
    if (t) return 2;
    if (n) return 3;
    if (m) return 4;
    return 0;
  endfunction

  initial begin
    int unsigned seed;
    bit m_div, m_nmi, m_ie, m_tf;
    seed = $urandom(32'd2718);
    do_reset();

    // R1 reset state
    chk("R1 take", take_o, 0);
    chk("R1 ack", ack_o, 0);
    chk("R1 ie", ie_o, 0);
    chk("R1 tf", tf_o, 0);
    boundary_strobe();
    chk("R1 no entry after reset", take_o, 0);

    // R7 maskable while disabled
    mreq_i = 1'b1;
    boundary_strobe();
    chk("R7 ack while disabled", ack_o, 0);
    chk("R7 take while disabled", take_o, 0);
    mreq_i = 1'b0;

    // R2 glitch dropped
    nmi_pulse(1);
    boundary_strobe();
    chk("R2 short pulse dropped", take_o, 0);

    // R3 / R4 nmi held high
    nmi_async_i = 1'b1;
    tick(6);
    chk("R3 no entry before boundary", take_o, 0);
    boundary_strobe();
    chk("R3 nmi taken with ie=0", take_o, 1);
    chk("R3 nmi vector", vec_o, 8'h02);
    tick(2);
    boundary_strobe();
    chk("R4 held line no retrigger", take_o, 0);
    nmi_async_i = 1'b0;
    tick(4);
    nmi_pulse(3);
    boundary_strobe();
    chk("R4 new request taken", take_o, 1);
    chk("R4 new request vector", vec_o, 8'h02);
    tick(1);
    chk("R11 take one cycle", take_o, 0);

    // R8 late maskable waits
    write_flags(1'b1, 1'b0);
    type_i = 8'hA5;
    boundary_i = 1'b1;
    tick(1);
    boundary_i = 1'b0;
    mreq_i = 1'b1;
    chk("R8 late rise no ack", ack_o, 0);
    tick(1);
    chk("R8 late rise no ack later", ack_o, 0);
    tick(2);
    boundary_strobe();
    chk("R8 ack at next boundary", ack_o, 1);
    chk("R9 no take during ack", take_o, 0);
    chk("R10 ie cleared on entry", ie_o, 0);
    // R11 boundary during ack ignored; div pulse latched
    boundary_i = 1'b1; div_err_i = 1'b1;
    tick(1);
    boundary_i = 1'b0; div_err_i = 1'b0; mreq_i = 1'b0;
    chk("R9 take after ack", take_o, 1);
    chk("R9 captured type", vec_o, 8'hA5);
    chk("R9 ack one cycle", ack_o, 0);
    tick(1);
    chk("R11 no entry from ack-cycle boundary", take_o, 0);
    chk("R11 no second ack", ack_o, 0);
    tick(3);
    chk("R6 div held no entry", take_o, 0);
    boundary_strobe();
    chk("R6 div taken later", take_o, 1);
    chk("R6 div vector", vec_o, 8'h00);

    // R10 clear wins over same-edge write
    write_flags(1'b0, 1'b1);
    ie_wr_i = 1'b1; ie_val_i = 1'b1; tf_wr_i = 1'b1; tf_val_i = 1'b1;
    boundary_i = 1'b1;
    tick(1);
    boundary_i = 1'b0; ie_wr_i = 1'b0; tf_wr_i = 1'b0;
    chk("R5 trap vector", vec_o, 8'h01);
    chk("R10 ie clear wins", ie_o, 0);
    chk("R10 tf clear wins", tf_o, 0);

    // R5 random mix against a bench model
    do_reset();
    m_div = 0; m_nmi = 0;
    for (int it = 0; it < 60; it++) begin
      bit d_nmi, d_div, d_mreq;
      int src;
      m_ie = $urandom % 2; m_tf = ($urandom % 4) == 0;
      d_nmi = ($urandom % 3) == 0; d_div = ($urandom % 4) == 0; d_mreq = $urandom % 2;
      type_i = 8'($urandom);
      write_flags(m_ie, m_tf);
      if (d_nmi) begin nmi_pulse(3); m_nmi = 1; end
      if (d_div) begin div_err_i = 1'b1; tick(1); div_err_i = 1'b0; m_div = 1; end
      mreq_i = d_mreq;
      src = exp_src(m_div, m_tf, m_nmi, d_mreq && m_ie);
      boundary_strobe();
      if (src == 0) begin
        chk("R5 random none take", take_o, 0);
        chk("R5 random none ack", ack_o, 0);
      end else if (src == 4) begin
        chk("R9 random ack", ack_o, 1);
        tick(1);
        chk("R9 random take", take_o, 1);
        chk("R9 random type", vec_o, type_i);
      end else begin
        chk("R5 random take", take_o, 1);
        chk("R5 random vector", vec_o, src - 1);
        chk("R10 random ie", ie_o, 0);
        if (src == 1) m_div = 0;
        if (src == 3) m_nmi = 0;
      end
      mreq_i = 1'b0;
      tick(1);
      chk("R11 random pulse end", take_o, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule